// File: doc/BRIEF.md
# Interleaved Dual-Converter Sample Packer

Two analog-to-digital converters sample one input at alternating instants and share a single sample clock. On each clock, converter A delivers the earlier sample of a pair and converter B the later one. This block merges the two buses into one time-ordered stream at twice the rate of a single converter. It then packs that stream into 64-bit words sized for the buffer memory bus.

A runtime resolution select picks one of two packings. Full-precision mode keeps every 14-bit sample, sign-extended to a 16-bit lane, so four samples fill a word. Reduced mode keeps only the eight most significant bits of each sample, so eight samples fill a word; this mode suits frequency measurement, where the coarser samples halve the memory bandwidth.

The enable input gates acquisition. Dropping it throws away any partly built word, so a word only ever holds samples from one unbroken run. Each finished word is presented for a single cycle with a valid strobe.

Top module: `samplePacker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wordValid` is 0 and `wordData` is all zeros.
- R2: Samples land in time order: within a pair, the A sample comes before the B sample, and pairs follow the order of the clocks that carried them. The earliest sample of a word sits in the least significant lane (bits 15:0 in full mode, bits 7:0 in reduced mode).
- R3: With `resSel` = 0 (full mode), each sample is sign-extended from bit 13 into a 16-bit lane. Four lanes fill a word, so a word completes every 2 enabled cycles.
- R4: With `resSel` = 1 (reduced mode), each lane holds bits 13:6 of a sample. Eight 8-bit lanes fill a word, so a word completes every 4 enabled cycles.
- R5: A sample pair is taken only on a cycle with `enable` high. A word is emitted only after its full set of pairs has been taken on consecutive enabled cycles.
- R6: `resSel` is sampled only on the first pair of a word. A change while a word is being built takes effect from the next word.
- R7: When `enable` drops, the partly built word is discarded. The first pair taken after `enable` returns starts a new word in lane 0.
- R8: `wordValid` is a one-cycle pulse, high on the cycle after the clock edge that took the last pair of a word. `wordData` holds its value whenever `wordValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Take the current sample pair when high |
| resSel | input | 1 | 1 = reduced 8-bit packing, 0 = full 14-bit packing |
| sampA | input | 14 | Converter A sample, two's complement, earlier instant |
| sampB | input | 14 | Converter B sample, two's complement, later instant |
| wordValid | output | 1 | Pulses for one cycle per completed word |
| wordData | output | 64 | Packed word |

## Verification
The checker watches three things on every cycle. It confirms that the valid strobe is never high two cycles running. It confirms that a word only appears after at least two enabled cycles in a row. It confirms that the output word holds still between strobes. Lane contents are a different matter and only the bench's scenarios can show them. These include the lane order, sign extension versus truncation, the point at which a resolution change takes effect, and the discarding of a partial word. The bench drives ramps, extreme codes, mid-word mode flips and broken enable runs, and compares every cycle against a behavioural model.

// File: rtl/packer_pkg.sv
package packer_pkg;
  localparam int SAMPLE_W = 14;
  localparam int WORD_W   = 64;
  localparam int NARROW_W = 8;
  localparam int WIDE_W   = 16;

  localparam int NARROW_LANES = WORD_W / NARROW_W;
  localparam int WIDE_LANES   = WORD_W / WIDE_W;
  localparam int NARROW_PAIRS = NARROW_LANES / 2;
  localparam int WIDE_PAIRS   = WIDE_LANES / 2;
  localparam int IDX_W        = (NARROW_PAIRS > 1) ? $clog2(NARROW_PAIRS) : 1;

  // Strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic             capture;  // take the current pair
    logic             narrow;   // packing mode that applies to this pair
    logic [IDX_W-1:0] pairIdx;  // pair slot within the word being built
    logic             finish;   // this pair completes the word
    logic             clear;    // drop the partial word
  } packStrobe_t;
endpackage

// File: rtl/packCtrl.sv
module packCtrl
  import packer_pkg::*;
#(
  parameter int N_PAIRS = NARROW_PAIRS,
  parameter int W_PAIRS = WIDE_PAIRS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        resSel,
  output packStrobe_t strb
);
  logic [IDX_W-1:0] pairCnt;
  logic             heldNarrow;
  logic             modeNow;
  logic             lastPair;

  // The mode is latched on the first pair of a word only
  always_comb begin
    modeNow  = (pairCnt == '0) ? resSel : heldNarrow;
    lastPair = modeNow ? (pairCnt == IDX_W'(N_PAIRS - 1))
                       : (pairCnt == IDX_W'(W_PAIRS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairCnt    <= '0;
      heldNarrow <= 1'b0;
    end else if (!enable) begin
      pairCnt    <= '0;
    end else begin
      heldNarrow <= modeNow;
      pairCnt    <= lastPair ? '0 : pairCnt + 1'b1;
    end
  end

  always_comb begin
    strb.capture = enable;
    strb.narrow  = modeNow;
    strb.pairIdx = pairCnt;
    strb.finish  = enable && lastPair;
    strb.clear   = !enable;
  end
endmodule

// File: rtl/packDatapath.sv
module packDatapath
  import packer_pkg::*;
#(
  parameter int S_W = SAMPLE_W,
  parameter int D_W = WORD_W,
  parameter int N_W = NARROW_W,
  parameter int W_W = WIDE_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  packStrobe_t    strb,
  input  logic [S_W-1:0] sampA,
  input  logic [S_W-1:0] sampB,
  output logic           wordValid,
  output logic [D_W-1:0] wordData
);
  localparam int NL  = D_W / N_W;
  localparam int WL  = D_W / W_W;
  localparam int EXT = W_W - S_W;

  logic [D_W-1:0] acc;
  logic [D_W-1:0] narrowNext;
  logic [D_W-1:0] wideNext;
  logic [D_W-1:0] accNext;

  logic [N_W-1:0] aNarrow, bNarrow;
  logic [W_W-1:0] aWide, bWide;

  // Reduced mode keeps the top bits; full mode sign-extends
  assign aNarrow = sampA[S_W-1 -: N_W];
  assign bNarrow = sampB[S_W-1 -: N_W];
  assign aWide   = {{EXT{sampA[S_W-1]}}, sampA};
  assign bWide   = {{EXT{sampB[S_W-1]}}, sampB};

  // Even lanes take A, odd lanes take B, two lanes per pair slot
  for (genvar g = 0; g < NL; g++) begin : gNarrowLane
    assign narrowNext[g*N_W +: N_W] =
      (strb.pairIdx == IDX_W'(g / 2)) ? ((g % 2 == 0) ? aNarrow : bNarrow)
                                      : acc[g*N_W +: N_W];
  end

  for (genvar g = 0; g < WL; g++) begin : gWideLane
    assign wideNext[g*W_W +: W_W] =
      (strb.pairIdx == IDX_W'(g / 2)) ? ((g % 2 == 0) ? aWide : bWide)
                                      : acc[g*W_W +: W_W];
  end

  assign accNext = strb.narrow ? narrowNext : wideNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      wordData  <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strb.finish;
      if (strb.finish) begin
        wordData <= accNext;
        acc      <= '0;
      end else if (strb.capture) begin
        acc      <= accNext;
      end else if (strb.clear) begin
        acc      <= '0;
      end
    end
  end
endmodule

// File: rtl/samplePacker.sv
module samplePacker
  import packer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                resSel,
  input  logic [SAMPLE_W-1:0] sampA,
  input  logic [SAMPLE_W-1:0] sampB,
  output logic                wordValid,
  output logic [WORD_W-1:0]   wordData
);
  packStrobe_t strb;

  packCtrl #(
    .N_PAIRS(NARROW_PAIRS),
    .W_PAIRS(WIDE_PAIRS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .resSel(resSel), .strb(strb)
  );

  packDatapath #(
    .S_W(SAMPLE_W), .D_W(WORD_W), .N_W(NARROW_W), .W_W(WIDE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sampA(sampA), .sampB(sampB),
    .wordValid(wordValid), .wordData(wordData)
  );
endmodule

// File: rtl/packerChecker.sv
module packerChecker
  import packer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordData
);
  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R5
  enabled_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> ($past(enable) && $past(enable, 2)));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordData));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!wordValid && wordData == '0));
endmodule

bind samplePacker packerChecker u_packerChecker (
  .clk(clk), .rstN(rstN), .enable(enable),
  .wordValid(wordValid), .wordData(wordData)
);

// File: tb/test_samplePacker.sv
module test_samplePacker;
  import packer_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                enable = 1'b0;
  logic                resSel = 1'b0;
  logic [SAMPLE_W-1:0] sampA = '0;
  logic [SAMPLE_W-1:0] sampB = '0;
  logic                wordValid;
  logic [WORD_W-1:0]   wordData;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string curReq = "R1";

  // Behavioural reference
  int                mFill = 0;
  bit                mNarrow = 0;
  logic [WORD_W-1:0] mAcc = '0;
  bit                expValid = 0;
  logic [WORD_W-1:0] expData = '0;

  samplePacker i_samplePacker (
    .clk(clk), .rstN(rstN), .enable(enable), .resSel(resSel),
    .sampA(sampA), .sampB(sampB),
    .wordValid(wordValid), .wordData(wordData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic putSample(logic [SAMPLE_W-1:0] s);
    if (mNarrow) mAcc[mFill*NARROW_W +: NARROW_W] = s[SAMPLE_W-1 -: NARROW_W];
    else         mAcc[mFill*WIDE_W +: WIDE_W] = {{(WIDE_W-SAMPLE_W){s[SAMPLE_W-1]}}, s};
    mFill++;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      expValid = 0; expData = '0; mFill = 0; mAcc = '0;
    end else begin
      expValid = 0;
      if (!enable) mFill = 0;
      else begin
        if (mFill == 0) mNarrow = resSel;
        putSample(sampA);
        putSample(sampB);
        if (mFill == (mNarrow ? NARROW_LANES : WIDE_LANES)) begin
          expData = mAcc; expValid = 1; mFill = 0;
        end
      end
    end
  end

  // Compare away from the active edge, every cycle after reset
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, {63'b0, wordValid}, {63'b0, expValid});
      if (expValid) check(curReq, wordData, expData);
    end
  end

  task automatic drive(bit en, bit sel, logic [SAMPLE_W-1:0] a, logic [SAMPLE_W-1:0] b);
    @(negedge clk);
    enable = en; resSel = sel; sampA = a; sampB = b;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {63'b0, wordValid}, 64'd0);
    check("R1", wordData, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {63'b0, wordValid}, 64'd0);
    check("R1", wordData, 64'd0);

    // R2: ramp in full mode, hand-computed word
    curReq = "R2";
    drive(1, 0, 14'd1, 14'd2);
    drive(1, 0, 14'd3, 14'd4);
    drive(0, 0, 14'd0, 14'd0);
    check("R2", {63'b0, wordValid}, 64'd1);
    check("R2", wordData, 64'h0004_0003_0002_0001);

    // R3: extreme codes for sign extension
    curReq = "R3";
    drive(1, 0, 14'h2000, 14'h1FFF);
    drive(1, 0, 14'h3FFF, 14'h0000);
    drive(0, 0, 14'd0, 14'd0);
    check("R3", wordData, 64'h0000_FFFF_1FFF_E000);
    for (int i = 0; i < 40; i++) drive(1, 0, 14'($urandom), 14'($urandom));

    // R4: reduced mode, ramp then random
    curReq = "R4";
    drive(0, 1, 14'd0, 14'd0);
    for (int i = 0; i < 4; i++)
      drive(1, 1, 14'((2*i+1) << 6), 14'((2*i+2) << 6));
    drive(0, 1, 14'd0, 14'd0);
    check("R4", wordData, 64'h0807_0605_0403_0201);
    for (int i = 0; i < 40; i++) drive(1, 1, 14'($urandom), 14'($urandom));

    // R5: sparse enable never completes a word
    curReq = "R5";
    for (int i = 0; i < 20; i++) drive(i % 2 == 0, i % 4 < 2, 14'($urandom), 14'($urandom));
    drive(0, 0, 14'd0, 14'd0);

    // R6: flip resSel inside words of both modes
    curReq = "R6";
    for (int i = 0; i < 48; i++) drive(1, (i % 3) == 1, 14'($urandom), 14'($urandom));
    drive(0, 1, 14'd0, 14'd0);
    drive(1, 1, 14'h3FC0, 14'h0040);
    drive(1, 0, 14'h0080, 14'h00C0);
    drive(1, 0, 14'h0100, 14'h0140);
    drive(1, 0, 14'h0180, 14'h01C0);
    drive(0, 0, 14'd0, 14'd0);
    check("R6", wordData, 64'h0706_0504_0302_01FF);

    // R7: drop enable mid-word, then restart at lane 0
    curReq = "R7";
    drive(1, 0, 14'd9, 14'd9);
    drive(0, 0, 14'd7, 14'd7);
    drive(1, 0, 14'd5, 14'd6);
    drive(1, 0, 14'd7, 14'd8);
    drive(0, 0, 14'd0, 14'd0);
    check("R7", wordData, 64'h0008_0007_0006_0005);
    for (int i = 0; i < 60; i++) drive(($urandom % 5) != 0, $urandom % 2, 14'($urandom), 14'($urandom));

    // R8: long continuous run, pulses compared every cycle
    curReq = "R8";
    for (int i = 0; i < 64; i++) drive(1, i >= 32, 14'($urandom), 14'($urandom));
    drive(0, 0, 14'd0, 14'd0);
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule